// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port. A small register file holds its settings: the character format, a 12-bit bit-rate divisor, and the controls. The format sets 7 or 8 data bits, optional odd or even parity, and one or two stop bits. The controls are separate receive and transmit enables, break, loopback and two interrupt enables. Software pushes characters into an 8-entry transmit FIFO through the data register. Received characters collect in an 8-entry receive FIFO, and each one carries its own parity-error and framing-error flags. A single interrupt line is raised by FIFO fill thresholds.

The data path runs through a plain strobe-based register port, so it has no handshake and applies no back-pressure. A write to a full transmit FIFO is discarded. A character that arrives while the receive FIFO is full is also discarded. Either loss sets a sticky overrun status bit. Software keeps within the FIFO limits by polling the status register or by acting on the threshold interrupts.

Register addresses:

| Address | Name | Fields |
|---|---|---|
| 0 | format | [0] parity on, [1] even parity, [2] two stop bits, [3] 8-bit characters |
| 1 | divisor high | bits [11:8] of the divisor |
| 2 | divisor low | bits [7:0] of the divisor |
| 3 | control | [0] receive on, [1] transmit on, [2] break, [3] receive interrupt on, [4] transmit interrupt on, [5] loopback |
| 4 | data | a write pushes to the transmit FIFO; a read pops the receive FIFO |
| 5 | status | see R10 |

Top module: `sercom_uart`

## Requirements
- R1: After reset, txd is high and irq is low. Registers 0 to 3 read 0. The status register reads 0x20, which means both FIFOs are empty, the transmitter is idle and no overrun is flagged.
- R2: The divisor D is formed as {divisor high[3:0], divisor low[7:0]}. Every transmitted bit lasts exactly 16*(D+1) clock cycles.
- R3: A transmitted frame is sent in this order: a low start bit, then the data bits LSB first (7 bits when format[3]=0, 8 bits when it is 1), then a parity bit when format[0]=1, then one high stop bit (or two when format[2]=1). The line idles high. The parity bit makes the total number of ones even when format[1]=1 and odd when format[1]=0.
- R4: The receiver accepts frames in every format. It detects the start bit on a falling edge and checks it and each later bit at mid-bit, on the 8th of 16 ticks. In 7-bit mode the stored character has bit 7 equal to 0.
- R5: A received character with the wrong parity is stored with its parity-error flag set. Status bit 3 shows this flag while that character is at the head of the receive FIFO.
- R6: A received character with a low stop bit is stored with its framing-error flag set. Status bit 4 shows this flag while that character is at the head of the receive FIFO.
- R7: While control[1]=0 the transmitter starts no frame, and written characters wait in the FIFO (status bit 5 = 0). While control[0]=0 the receiver ignores the line.
- R8: While control[2]=1, txd is held low.
- R9: While control[5]=1, the receiver takes its input from the transmitter output and ignores the rxd pin.
- R10: Both FIFOs hold 8 entries and keep first-in first-out order. Status bits are: [0] receive FIFO not empty, [1] transmit FIFO full, [2] overrun, [5] transmitter idle (FIFO empty and no frame in progress), [6] receive FIFO full. A dropped write or a dropped received character sets the sticky overrun bit. Writing 1 to status bit 2 clears it.
- R11: irq = (control[3] and receive FIFO count >= 4) or (control[4] and transmit FIFO count <= 4).
- R12: Registers 0 to 3 read back the written fields. Unused bits read 0. A read returns its data one cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| reg_wr | input | 1 | register write strobe |
| reg_rd | input | 1 | register read strobe; a read of the data register pops the receive FIFO |
| reg_addr | input | 3 | register address |
| reg_wdata | input | 8 | write data |
| reg_rdata | output | 8 | read data, registered, valid the cycle after reg_rd |
| rxd | input | 1 | serial receive line |
| txd | output | 1 | serial transmit line |
| irq | output | 1 | threshold interrupt request |

## Verification
The assertions take three things for granted. First, the divisor and the format stay unchanged while a frame is in flight. Second, an externally driven rxd idles high. Third, an externally driven rxd changes only on whole bit-period boundaries. The bench reconfigures the block only when both directions are idle. It drives rxd for exactly 16*(D+1) cycles per bit and returns rxd high after every frame. During the loopback sweep it holds rxd low, so that any leakage of the pin into the receiver would show up.

// File: rtl/sercom_uart_pkg.sv
package sercom_uart_pkg;

  typedef struct packed {
    logic eight;
    logic two_stop;
    logic par_even;
    logic par_en;
  } fmt_t;

  typedef enum logic [2:0] {PH_IDLE, PH_START, PH_DATA, PH_PAR, PH_STOP} phase_t;

  localparam logic [2:0] ADDR_FMT  = 3'd0;
  localparam logic [2:0] ADDR_DIVH = 3'd1;
  localparam logic [2:0] ADDR_DIVL = 3'd2;
  localparam logic [2:0] ADDR_CTL  = 3'd3;
  localparam logic [2:0] ADDR_DATA = 3'd4;
  localparam logic [2:0] ADDR_STAT = 3'd5;

  localparam int CTL_RXEN = 0;
  localparam int CTL_TXEN = 1;
  localparam int CTL_BRK  = 2;
  localparam int CTL_RXIE = 3;
  localparam int CTL_TXIE = 4;
  localparam int CTL_LOOP = 5;
  localparam int CTL_W    = 6;

  localparam int ST_OVR = 2;

  // Parity bit that completes the character to the selected sense.
  function automatic logic parity_bit(input logic [7:0] d, input fmt_t f);
    logic ones;
    ones = f.eight ? ^d : ^d[6:0];
    return ones ^ ~f.par_even;
  endfunction

endpackage

// File: rtl/sercom_uart_baud.sv
module sercom_uart_baud #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = (cnt_q >= div_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R2: with a nonzero divisor, ticks are never on adjacent cycles
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && div_i != '0) |=> (!tick_o || div_i != $past(div_i)));
endmodule

// File: rtl/sercom_uart_fifo.sv
module sercom_uart_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic          pop_i,
  output logic [W-1:0]  head_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          drop_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_pop, do_push;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && (!full_o || do_pop);
  assign drop_o  = push_i && !do_push;
  assign head_o  = mem[rp_q];
  assign count_o = cnt_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= bump(wp_q);
      if (do_pop)  rp_q <= bump(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  p_drop_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    drop_o |=> full_o);
endmodule

// File: rtl/sercom_uart_tx.sv
module sercom_uart_tx
  import sercom_uart_pkg::*;
#(
  parameter int OVS = 16,
  localparam int TW = $clog2(OVS)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       en_i,
  input  fmt_t       fmt_i,
  input  logic       avail_i,
  input  logic [7:0] data_i,
  output logic       pop_o,
  output logic       line_o,
  output logic       busy_o
);
  phase_t        ph_q;
  logic [TW-1:0] tcnt_q;
  logic [2:0]    idx_q;
  logic [7:0]    sh_q;
  logic          pbit_q, stop2_q, line_q;
  fmt_t          fmt_q;

  assign pop_o  = (ph_q == PH_IDLE) && tick_i && en_i && avail_i;
  assign line_o = line_q;
  assign busy_o = (ph_q != PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE; tcnt_q <= '0; idx_q <= '0; sh_q <= '0;
      pbit_q <= 1'b0; stop2_q <= 1'b0; line_q <= 1'b1; fmt_q <= '0;
    end else if (ph_q == PH_IDLE) begin
      line_q <= 1'b1;
      if (pop_o) begin
        ph_q   <= PH_START;
        line_q <= 1'b0;
        sh_q   <= data_i;
        pbit_q <= parity_bit(data_i, fmt_i);
        fmt_q  <= fmt_i;
        tcnt_q <= '0;
      end
    end else if (tick_i) begin
      if (tcnt_q != TW'(OVS - 1)) begin
        tcnt_q <= tcnt_q + 1'b1;
      end else begin
        tcnt_q <= '0;
        case (ph_q)
          PH_START: begin
            ph_q <= PH_DATA; idx_q <= '0;
            line_q <= sh_q[0]; sh_q <= sh_q >> 1;
          end
          PH_DATA: begin
            if (idx_q == (fmt_q.eight ? 3'd7 : 3'd6)) begin
              stop2_q <= 1'b0;
              if (fmt_q.par_en) begin ph_q <= PH_PAR;  line_q <= pbit_q; end
              else              begin ph_q <= PH_STOP; line_q <= 1'b1;   end
            end else begin
              idx_q <= idx_q + 1'b1;
              line_q <= sh_q[0]; sh_q <= sh_q >> 1;
            end
          end
          PH_PAR: begin ph_q <= PH_STOP; line_q <= 1'b1; end
          PH_STOP: begin
            if (fmt_q.two_stop && !stop2_q) stop2_q <= 1'b1;
            else                            ph_q <= PH_IDLE;
          end
          default: ph_q <= PH_IDLE;
        endcase
      end
    end
  end

  // R3: the start bit is always low on the line
  p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_START) |-> !line_o);
endmodule

// File: rtl/sercom_uart_rx.sv
module sercom_uart_rx
  import sercom_uart_pkg::*;
#(
  parameter int OVS = 16,
  localparam int TW = $clog2(OVS)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       en_i,
  input  fmt_t       fmt_i,
  input  logic       line_i,
  output logic       push_o,
  output logic [7:0] char_o,
  output logic       pe_o,
  output logic       fe_o
);
  phase_t        ph_q;
  logic [TW-1:0] tcnt_q;
  logic [2:0]    idx_q;
  logic [7:0]    sh_q, chr, char_q;
  logic          prev_q, pbit_q, stop2_q, fe_acc_q;
  logic          push_q, pe_q, fe_q;
  fmt_t          fmt_q;

  assign chr    = fmt_q.eight ? sh_q : {1'b0, sh_q[7:1]};
  assign push_o = push_q;
  assign char_o = char_q;
  assign pe_o   = pe_q;
  assign fe_o   = fe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE; tcnt_q <= '0; idx_q <= '0; sh_q <= '0; char_q <= '0;
      prev_q <= 1'b1; pbit_q <= 1'b0; stop2_q <= 1'b0; fe_acc_q <= 1'b0;
      push_q <= 1'b0; pe_q <= 1'b0; fe_q <= 1'b0; fmt_q <= '0;
    end else begin
      push_q <= 1'b0;
      prev_q <= line_i;
      if (!en_i) begin
        ph_q <= PH_IDLE;
      end else if (ph_q == PH_IDLE) begin
        if (prev_q && !line_i) begin
          ph_q <= PH_START; tcnt_q <= '0; fmt_q <= fmt_i;
        end
      end else if (tick_i) begin
        tcnt_q <= tcnt_q + 1'b1;
        if (ph_q == PH_START) begin
          if (tcnt_q == TW'(OVS / 2 - 1)) begin
            tcnt_q <= '0;
            if (line_i) ph_q <= PH_IDLE;
            else begin ph_q <= PH_DATA; idx_q <= '0; fe_acc_q <= 1'b0; end
          end
        end else if (tcnt_q == TW'(OVS - 1)) begin
          tcnt_q <= '0;
          case (ph_q)
            PH_DATA: begin
              sh_q <= {line_i, sh_q[7:1]};
              if (idx_q == (fmt_q.eight ? 3'd7 : 3'd6)) begin
                stop2_q <= 1'b0;
                ph_q <= fmt_q.par_en ? PH_PAR : PH_STOP;
              end else begin
                idx_q <= idx_q + 1'b1;
              end
            end
            PH_PAR: begin pbit_q <= line_i; ph_q <= PH_STOP; end
            PH_STOP: begin
              if (fmt_q.two_stop && !stop2_q) begin
                stop2_q <= 1'b1;
                fe_acc_q <= fe_acc_q | !line_i;
              end else begin
                ph_q   <= PH_IDLE;
                push_q <= 1'b1;
                char_q <= chr;
                pe_q   <= fmt_q.par_en && (parity_bit(chr, fmt_q) != pbit_q);
                fe_q   <= fe_acc_q | !line_i;
              end
            end
            default: ph_q <= PH_IDLE;
          endcase
        end
      end
    end
  end

  // R4: a received character is delivered as a single-cycle push
  p_push_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |=> !push_o);
endmodule

// File: rtl/sercom_uart.sv
module sercom_uart
  import sercom_uart_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int RX_LEVEL   = 4,
  parameter int TX_LEVEL   = 4,
  parameter int DIV_W      = 12,
  parameter int OVS        = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       rxd,
  output logic       txd,
  output logic       irq
);
  localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);
  localparam int DIVH_W = DIV_W - 8;

  fmt_t              fmt_q;
  logic [DIVH_W-1:0] divh_q;
  logic [7:0]        divl_q;
  logic [CTL_W-1:0]  ctl_q;
  logic              ovr_q;
  logic [7:0]        rdata_q, rd_mux, status;

  logic              tick, tx_pop, tx_line, tx_busy, rx_push, rx_pe, rx_fe;
  logic [7:0]        tx_head, rx_char;
  logic [9:0]        rx_head;
  logic [CNT_W-1:0]  tx_cnt, rx_cnt;
  logic              tx_full, tx_empty, tx_drop, rx_full, rx_empty, rx_drop;
  logic              wr_data, rd_data, ovr_clr;
  logic [1:0]        sync_q;
  logic              rx_src;

  assign wr_data = reg_wr && (reg_addr == ADDR_DATA);
  assign rd_data = reg_rd && (reg_addr == ADDR_DATA);
  assign ovr_clr = reg_wr && (reg_addr == ADDR_STAT) && reg_wdata[ST_OVR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q <= '0; divh_q <= '0; divl_q <= '0; ctl_q <= '0; ovr_q <= 1'b0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          ADDR_FMT:  fmt_q  <= reg_wdata[3:0];
          ADDR_DIVH: divh_q <= reg_wdata[DIVH_W-1:0];
          ADDR_DIVL: divl_q <= reg_wdata;
          ADDR_CTL:  ctl_q  <= reg_wdata[CTL_W-1:0];
          default: ;
        endcase
      end
      if (tx_drop || rx_drop) ovr_q <= 1'b1;
      else if (ovr_clr)       ovr_q <= 1'b0;
    end
  end

  assign status = {1'b0, rx_full, tx_empty && !tx_busy,
                   rx_head[9] && !rx_empty, rx_head[8] && !rx_empty,
                   ovr_q, tx_full, !rx_empty};

  always_comb begin
    case (reg_addr)
      ADDR_FMT:  rd_mux = {4'b0, fmt_q};
      ADDR_DIVH: rd_mux = {{(8 - DIVH_W){1'b0}}, divh_q};
      ADDR_DIVL: rd_mux = divl_q;
      ADDR_CTL:  rd_mux = {{(8 - CTL_W){1'b0}}, ctl_q};
      ADDR_DATA: rd_mux = rx_empty ? 8'h00 : rx_head[7:0];
      ADDR_STAT: rd_mux = status;
      default:   rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= 8'h00;
    else if (reg_rd) rdata_q <= rd_mux;
  end
  assign reg_rdata = rdata_q;

  sercom_uart_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .div_i({divh_q, divl_q}), .tick_o(tick));

  sercom_uart_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push_i(wr_data), .din_i(reg_wdata),
    .pop_i(tx_pop), .head_o(tx_head), .count_o(tx_cnt),
    .full_o(tx_full), .empty_o(tx_empty), .drop_o(tx_drop));

  sercom_uart_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .en_i(ctl_q[CTL_TXEN]),
    .fmt_i(fmt_q), .avail_i(!tx_empty), .data_i(tx_head),
    .pop_o(tx_pop), .line_o(tx_line), .busy_o(tx_busy));

  assign txd    = ctl_q[CTL_BRK] ? 1'b0 : tx_line;
  assign rx_src = ctl_q[CTL_LOOP] ? txd : rxd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rx_src};
  end

  sercom_uart_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .en_i(ctl_q[CTL_RXEN]),
    .fmt_i(fmt_q), .line_i(sync_q[1]), .push_o(rx_push),
    .char_o(rx_char), .pe_o(rx_pe), .fe_o(rx_fe));

  sercom_uart_fifo #(.W(10), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push_i(rx_push), .din_i({rx_fe, rx_pe, rx_char}),
    .pop_i(rd_data), .head_o(rx_head), .count_o(rx_cnt),
    .full_o(rx_full), .empty_o(rx_empty), .drop_o(rx_drop));

  assign irq = (ctl_q[CTL_RXIE] && (rx_cnt >= CNT_W'(RX_LEVEL))) ||
               (ctl_q[CTL_TXIE] && (tx_cnt <= CNT_W'(TX_LEVEL)));

  // R3: with no frame in progress and no break, the line idles high
  p_idle_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && !ctl_q[CTL_BRK]) |-> txd);
  // R7: a disabled transmitter never starts a frame
  p_tx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q[CTL_TXEN] && !tx_busy) |=> !tx_busy);
  // R10: overrun stays set until explicitly cleared
  p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !ovr_clr) |=> ovr_q);
  // R11: an empty transmit FIFO with its interrupt enabled requests service
  p_irq_tx_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[CTL_TXIE] && tx_empty) |-> irq);
endmodule

// File: tb/sercom_uart_test.sv
module sercom_uart_test;
  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0, rxd = 1'b1;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic txd, irq;
  int total = 0, fails = 0, bp = 16;
  bit done = 0;

  always #5 clk = ~clk;

  sercom_uart uut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rxd(rxd), .txd(txd), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  function automatic int flen(input logic [3:0] f);
    return 1 + (f[3] ? 8 : 7) + (f[0] ? 1 : 0) + (f[2] ? 2 : 1);
  endfunction

  function automatic logic [15:0] fbits(input logic [3:0] f, input logic [7:0] d);
    logic [15:0] b;
    int n, ones;
    b = '1; b[0] = 1'b0; n = 1; ones = 0;
    for (int i = 0; i < (f[3] ? 8 : 7); i++) begin
      b[n] = d[i]; ones += d[i]; n++;
    end
    if (f[0]) b[n] = f[1] ? (ones % 2 == 1) : (ones % 2 == 0);
    return b;
  endfunction

  task automatic cap_tx(input logic [3:0] f, output logic [15:0] got);
    got = '1;
    while (txd) @(negedge clk);
    repeat (bp / 2) @(negedge clk);
    got[0] = txd;
    for (int i = 1; i < flen(f); i++) begin
      repeat (bp) @(negedge clk);
      got[i] = txd;
    end
  endtask

  task automatic send_rx(input logic [3:0] f, input logic [7:0] d, input bit bad_par, input bit bad_stop);
    logic [15:0] b;
    int nb;
    b = fbits(f, d);
    nb = f[3] ? 8 : 7;
    if (bad_par) b[1 + nb] = ~b[1 + nb];
    if (bad_stop) b[1 + nb + (f[0] ? 1 : 0)] = 1'b0;
    for (int i = 0; i < flen(f); i++) begin
      @(negedge clk); rxd = b[i];
      repeat (bp - 1) @(negedge clk);
    end
    @(negedge clk); rxd = 1'b1;
    repeat (bp + 4) @(negedge clk);
  endtask

  task automatic measure_start(output int cyc);
    cyc = 0;
    while (txd) @(negedge clk);
    while (!txd) begin @(negedge clk); cyc++; end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [15:0] got;
    logic [7:0] pat [4];
    int cyc;
    bit seen;
    pat[0] = 8'h00; pat[1] = 8'hA5; pat[2] = 8'hFF; pat[3] = 8'h6E;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    chk("R1 txd", txd, 1); chk("R1 irq", irq, 0);
    rd(3'd5, v); chk("R1 status", v, 8'h20);
    rd(3'd0, v); chk("R1 format", v, 0);
    rd(3'd3, v); chk("R1 control", v, 0);
    rd(3'd1, v); chk("R1 divh", v, 0);

    // R12: readback
    wr(3'd0, 8'hFB); rd(3'd0, v); chk("R12 format", v, 8'h0B);
    wr(3'd2, 8'h5A); rd(3'd2, v); chk("R12 divl", v, 8'h5A);
    wr(3'd1, 8'hF3); rd(3'd1, v); chk("R12 divh", v, 8'h03);
    wr(3'd3, 8'hC0); rd(3'd3, v); chk("R12 control", v, 8'h00);
    wr(3'd1, 8'h00); wr(3'd2, 8'h00);

    // R3 R4 R9: every format, loopback with the pin held low
    wr(3'd3, 8'h23);
    rxd = 1'b0;
    for (int f = 0; f < 16; f++) begin
      wr(3'd0, 8'(f));
      for (int k = 0; k < 4; k++) begin
        wr(3'd4, pat[k]);
        cap_tx(4'(f), got);
        chk($sformatf("R3 frame fmt=%0d", f), got, fbits(4'(f), pat[k]));
        repeat (bp) @(negedge clk);
        rd(3'd5, v);
        chk($sformatf("R9 R5 R6 status fmt=%0d", f), v & 8'h19, 8'h01);
        rd(3'd4, v);
        chk($sformatf("R4 char fmt=%0d", f), v, f[3] ? pat[k] : (pat[k] & 8'h7F));
      end
    end
    rxd = 1'b1;
    repeat (4) @(negedge clk);
    wr(3'd3, 8'h00);

    // R2: bit period
    wr(3'd0, 8'h08); wr(3'd2, 8'h02); wr(3'd3, 8'h02);
    wr(3'd4, 8'hFF);
    measure_start(cyc); chk("R2 period D=2", cyc, 48);
    repeat (12 * 48) @(negedge clk);
    wr(3'd1, 8'h01); wr(3'd2, 8'h01);
    wr(3'd4, 8'hFF);
    measure_start(cyc); chk("R2 period D=257", cyc, 16 * 258);
    repeat (10 * 16 * 258) @(negedge clk);
    wr(3'd1, 8'h00); wr(3'd2, 8'h00);
    repeat (20) @(negedge clk);

    // R7: transmitter disabled holds data
    wr(3'd3, 8'h00); wr(3'd4, 8'h5C);
    seen = 0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (!txd) seen = 1; end
    chk("R7 tx held", seen, 0);
    rd(3'd5, v); chk("R7 waiting", v & 8'h20, 8'h00);
    wr(3'd3, 8'h02);
    cap_tx(4'h8, got); chk("R7 released frame", got, fbits(4'h8, 8'h5C));
    repeat (bp) @(negedge clk);
    send_rx(4'h8, 8'h33, 0, 0);
    rd(3'd5, v); chk("R7 rx disabled", v & 8'h01, 8'h00);

    // R4 R5 R6: external frames
    wr(3'd0, 8'h0B); wr(3'd3, 8'h01);
    send_rx(4'hB, 8'h96, 0, 0);
    rd(3'd5, v); chk("R5 good flags", v & 8'h19, 8'h01);
    rd(3'd4, v); chk("R4 good char", v, 8'h96);
    send_rx(4'hB, 8'h41, 1, 0);
    rd(3'd5, v); chk("R5 parity flag", v & 8'h19, 8'h09);
    rd(3'd4, v); chk("R5 parity char", v, 8'h41);
    send_rx(4'hB, 8'h7E, 0, 1);
    rd(3'd5, v); chk("R6 framing flag", v & 8'h19, 8'h11);
    rd(3'd4, v); chk("R6 framing char", v, 8'h7E);
    wr(3'd0, 8'h05);
    send_rx(4'h5, 8'hD3, 0, 0);
    rd(3'd5, v); chk("R4 7-bit flags", v & 8'h19, 8'h01);
    rd(3'd4, v); chk("R4 7-bit char", v, 8'h53);

    // R8: break
    wr(3'd3, 8'h06);
    seen = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (txd) seen = 1; end
    chk("R8 break low", seen, 0);
    wr(3'd3, 8'h02);
    chk("R8 break released", txd, 1);

    // R10 R11: FIFO depth, overrun, thresholds
    wr(3'd0, 8'h08); wr(3'd3, 8'h10);
    chk("R11 tx empty irq", irq, 1);
    for (int i = 0; i < 4; i++) wr(3'd4, 8'(i));
    chk("R11 tx count 4 irq", irq, 1);
    wr(3'd4, 8'd4);
    chk("R11 tx count 5 irq", irq, 0);
    for (int i = 5; i < 8; i++) wr(3'd4, 8'(i));
    rd(3'd5, v); chk("R10 tx full", v & 8'h06, 8'h02);
    wr(3'd4, 8'hEE);
    rd(3'd5, v); chk("R10 tx overrun", v & 8'h04, 8'h04);
    wr(3'd5, 8'h04);
    rd(3'd5, v); chk("R10 overrun clear", v & 8'h04, 8'h00);
    wr(3'd3, 8'h2B);
    repeat (8 * 10 * 16 + 200) @(negedge clk);
    chk("R11 rx irq full", irq, 1);
    rd(3'd5, v); chk("R10 rx full", v & 8'h45, 8'h41);
    wr(3'd4, 8'h99);
    repeat (250) @(negedge clk);
    rd(3'd5, v); chk("R10 rx overrun", v & 8'h04, 8'h04);
    for (int i = 0; i < 8; i++) begin
      rd(3'd4, v); chk($sformatf("R10 order %0d", i), v, 8'(i));
      if (i == 3) chk("R11 rx count 4 irq", irq, 1);
      if (i == 4) chk("R11 rx count 3 irq", irq, 0);
    end
    rd(3'd5, v); chk("R10 rx drained", v & 8'h01, 8'h00);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule